// File: doc/BRIEF.md
# SPI Nonvolatile Memory Slave Engine

This block is the slave side of a byte-addressed serial memory. A host reaches it over a four-wire SPI link made of an active-low select, a serial clock, data in and data out. The block brings those pins into its own system clock domain. It decodes a one-byte command, collects a three-byte address where the command needs one, and then streams data bytes to or from an internal synchronous RAM. The address advances after every byte, and no page limit applies in either direction.

A write-enable flag gates every change to the array and to the status byte. It is set by a dedicated command transaction and is dropped again when a modifying transaction ends. A sleep command takes effect only when select is released. While asleep the block ignores clock and data activity and leaves its output undriven. The next select assertion wakes it, that transaction is thrown away, and decoding resumes on the assertion after it.

Top module: `spi_nvram_slave`

## Requirements
- R1: After reset, miso_oe is low, the write-enable flag is clear and the status byte reads 00h.
- R2: Link modes 0 (clock idles low) and 3 (clock idles high) both work. Data in is taken on each rising clock edge and data out is valid for the host's next rising edge. Every byte travels most significant bit first.
- R3: Command 06h sets the write-enable flag when select rises. Command 05h returns the status byte, with the write-enable flag in bit 1, and keeps returning that byte for as long as the host clocks.
- R4: A write command (02h) or a status write (01h) that is not preceded by a completed 06h transaction changes neither the array nor the status byte.
- R5: Command 02h is followed by three address bytes, high byte first, of which the low ADDR_W bits are used. Every complete data byte after them is stored at the current address, which then increments and wraps from the top address to zero, for any number of bytes.
- R6: Command 03h is followed by three address bytes. The array is then streamed from that address, one byte per eight clocks, incrementing and wrapping from the top address to zero.
- R7: The write-enable flag clears when select rises at the end of a 02h, 01h or 04h transaction.
- R8: Command 01h with the flag set stores the first data byte into status bits 7, 3 and 2. Bit 1 stays the flag, and bits 6, 5, 4 and 0 always read 0.
- R9: Any other command byte is ignored until select rises. It does not drive data out and changes no state.
- R10: Command B9h, fully clocked, puts the block to sleep when select rises. While asleep, data out is undriven and the clock and data-in pins are ignored.
- R11: The first select assertion during sleep wakes the block and is discarded. The assertion after it is decoded normally.
- R12: A data byte left incomplete when select rises is not written.
- R13: miso_oe is high only while select is asserted in the data phase of a 03h or 05h command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the link |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select from the host, asynchronous |
| sck | input | 1 | Serial clock from the host, asynchronous |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, 0 when not driven |
| miso_oe | output | 1 | Output enable for the data-out pad |

## Verification
The assertions assume that every link pin holds each level for several system clocks. Each clock half-period must last at least four system cycles, and select must not change within a few cycles of a clock edge, so that each edge is seen exactly once after synchronization. The bench holds each clock level for five system cycles and places one half-period of margin on both sides of every select edge. It changes data in only while the clock is low. RAM contents are not reset, so the bench reads only locations it has written.

// File: rtl/spi_nvram_pkg.sv
package spi_nvram_pkg;

    localparam int BYTE_W     = 8;
    localparam int BIT_IDX_W  = $clog2(BYTE_W);
    localparam int ADDR_BYTES = 3;
    localparam int WEL_BIT    = 1;

    localparam logic [BYTE_W-1:0] CMD_SET_WE   = 8'h06;
    localparam logic [BYTE_W-1:0] CMD_CLR_WE   = 8'h04;
    localparam logic [BYTE_W-1:0] CMD_STAT_RD  = 8'h05;
    localparam logic [BYTE_W-1:0] CMD_STAT_WR  = 8'h01;
    localparam logic [BYTE_W-1:0] CMD_ARRAY_RD = 8'h03;
    localparam logic [BYTE_W-1:0] CMD_ARRAY_WR = 8'h02;
    localparam logic [BYTE_W-1:0] CMD_DOZE     = 8'hB9;

    // status bits the host may change; bit 1 mirrors the write-enable flag
    localparam logic [BYTE_W-1:0] STAT_WR_MASK = 8'h8C;

    typedef enum logic [2:0] {
        PH_OPCODE,
        PH_ADDR,
        PH_RDATA,
        PH_WDATA,
        PH_STATW,
        PH_STATR,
        PH_SKIP
    } phase_e;

    // action applied when select is released
    typedef enum logic [1:0] {
        END_NONE,
        END_SET_WE,
        END_CLR_WE,
        END_DOZE
    } endact_e;

    typedef struct packed {
        logic cs_act;
        logic cs_fall;
        logic cs_rise;
        logic sck_rise;
        logic din;
    } pin_ev_t;

    function automatic logic [BYTE_W-1:0] merge_status(
        input logic [BYTE_W-1:0] cur,
        input logic [BYTE_W-1:0] wr
    );
        return (cur & ~STAT_WR_MASK) | (wr & STAT_WR_MASK);
    endfunction

endpackage

// File: rtl/spi_nvram_pinsync.sv
module spi_nvram_pinsync
    import spi_nvram_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    cs_n,
    input  logic    sck,
    input  logic    mosi,
    output pin_ev_t ev
);

    localparam int NPIN  = 3;
    localparam int DEPTH = STAGES + 1;
    localparam logic [NPIN-1:0] IDLE_LVL = 3'b001;

    logic [NPIN-1:0] raw;
    logic [NPIN-1:0] cur;
    logic [NPIN-1:0] prev;

    assign raw = {mosi, sck, cs_n};

    generate
        for (genvar p = 0; p < NPIN; p++) begin : g_pin
            logic [DEPTH-1:0] sh;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sh <= {DEPTH{IDLE_LVL[p]}};
                end else begin
                    sh <= {sh[DEPTH-2:0], raw[p]};
                end
            end
            assign cur[p]  = sh[DEPTH-2];
            assign prev[p] = sh[DEPTH-1];
        end
    endgenerate

    always_comb begin
        ev.cs_act   = ~cur[0];
        ev.cs_fall  = prev[0] & ~cur[0];
        ev.cs_rise  = ~prev[0] & cur[0];
        ev.sck_rise = ~prev[1] & cur[1];
        ev.din      = cur[2];
    end

endmodule

// File: rtl/spi_nvram_rxbyte.sv
module spi_nvram_rxbyte
    import spi_nvram_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 shift,
    input  logic                 din,
    output logic [BIT_IDX_W-1:0] bit_idx,
    output logic                 byte_done,
    output logic [BYTE_W-1:0]    byte_val
);

    logic [BYTE_W-2:0] acc;

    assign byte_val  = {acc, din};
    assign byte_done = shift && (bit_idx == BIT_IDX_W'(BYTE_W - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            acc     <= '0;
            bit_idx <= '0;
        end else if (shift) begin
            acc     <= byte_val[BYTE_W-2:0];
            bit_idx <= bit_idx + 1'b1;
        end
    end

endmodule

// File: rtl/spi_nvram_array.sv
module spi_nvram_array #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/spi_nvram_slave.sv
module spi_nvram_slave
    import spi_nvram_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic sck,
    input  logic mosi,
    output logic miso,
    output logic miso_oe
);

    localparam int ACNT_W = $clog2(ADDR_BYTES);

    pin_ev_t              ev;
    logic                 active;
    logic                 shift;
    logic [BIT_IDX_W-1:0] bit_idx;
    logic                 byte_done;
    logic [BYTE_W-1:0]    byte_val;

    phase_e               phase_q;
    endact_e              endact_q;
    logic                 wel_q;
    logic                 sleep_q;
    logic                 wr_ok_q;
    logic                 is_wr_q;
    logic [ACNT_W-1:0]    acnt_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [BYTE_W-1:0]    stat_q;
    logic [BYTE_W-1:0]    stat_view;
    logic                 rd_req_q;
    logic                 rd_pend_q;
    logic [BYTE_W-1:0]    tx_q;
    logic [BYTE_W-1:0]    rd_data;
    logic                 we_q;
    logic [ADDR_W-1:0]    waddr_q;
    logic [BYTE_W-1:0]    wdata_q;
    logic [BYTE_W-1:0]    out_byte;

    spi_nvram_pinsync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sck  (sck),
        .mosi (mosi),
        .ev   (ev)
    );

    assign active = ev.cs_act & ~sleep_q;
    assign shift  = active & ev.sck_rise;

    spi_nvram_rxbyte u_rx (
        .clk       (clk),
        .rst       (rst),
        .clear     (ev.cs_fall | ev.cs_rise),
        .shift     (shift),
        .din       (ev.din),
        .bit_idx   (bit_idx),
        .byte_done (byte_done),
        .byte_val  (byte_val)
    );

    spi_nvram_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (BYTE_W)
    ) u_mem (
        .clk   (clk),
        .we    (we_q),
        .waddr (waddr_q),
        .wdata (wdata_q),
        .re    (rd_req_q),
        .raddr (addr_q),
        .rdata (rd_data)
    );

    always_comb begin
        stat_view          = stat_q;
        stat_view[WEL_BIT] = wel_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_OPCODE;
            endact_q  <= END_NONE;
            wel_q     <= 1'b0;
            sleep_q   <= 1'b0;
            wr_ok_q   <= 1'b0;
            is_wr_q   <= 1'b0;
            acnt_q    <= '0;
            addr_q    <= '0;
            stat_q    <= '0;
            rd_req_q  <= 1'b0;
            rd_pend_q <= 1'b0;
            tx_q      <= '0;
            we_q      <= 1'b0;
            waddr_q   <= '0;
            wdata_q   <= '0;
        end else begin
            we_q      <= 1'b0;
            rd_req_q  <= 1'b0;
            rd_pend_q <= rd_req_q;
            if (rd_req_q) begin
                addr_q <= addr_q + 1'b1;
            end
            if (rd_pend_q) begin
                tx_q <= rd_data;
            end

            if (ev.cs_fall) begin
                endact_q <= END_NONE;
                acnt_q   <= '0;
                if (sleep_q) begin
                    sleep_q <= 1'b0;
                    phase_q <= PH_SKIP;
                end else begin
                    phase_q <= PH_OPCODE;
                end
            end else if (ev.cs_rise) begin
                if (!sleep_q) begin
                    case (endact_q)
                        END_SET_WE: wel_q   <= 1'b1;
                        END_CLR_WE: wel_q   <= 1'b0;
                        END_DOZE:   sleep_q <= 1'b1;
                        default:    ;
                    endcase
                end
                endact_q <= END_NONE;
                phase_q  <= PH_OPCODE;
            end else if (byte_done) begin
                case (phase_q)
                    PH_OPCODE: begin
                        case (byte_val)
                            CMD_SET_WE: begin
                                phase_q  <= PH_SKIP;
                                endact_q <= END_SET_WE;
                            end
                            CMD_CLR_WE: begin
                                phase_q  <= PH_SKIP;
                                endact_q <= END_CLR_WE;
                            end
                            CMD_STAT_RD: begin
                                phase_q <= PH_STATR;
                            end
                            CMD_STAT_WR: begin
                                phase_q  <= PH_STATW;
                                endact_q <= END_CLR_WE;
                                wr_ok_q  <= wel_q;
                            end
                            CMD_ARRAY_RD: begin
                                phase_q <= PH_ADDR;
                                is_wr_q <= 1'b0;
                                acnt_q  <= '0;
                            end
                            CMD_ARRAY_WR: begin
                                phase_q  <= PH_ADDR;
                                is_wr_q  <= 1'b1;
                                acnt_q   <= '0;
                                endact_q <= END_CLR_WE;
                                wr_ok_q  <= wel_q;
                            end
                            CMD_DOZE: begin
                                phase_q  <= PH_SKIP;
                                endact_q <= END_DOZE;
                            end
                            default: begin
                                phase_q <= PH_SKIP;
                            end
                        endcase
                    end
                    PH_ADDR: begin
                        // older address bytes fall off the top of addr_q
                        addr_q <= ADDR_W'({addr_q, byte_val});
                        if (acnt_q == ACNT_W'(ADDR_BYTES - 1)) begin
                            if (is_wr_q) begin
                                phase_q <= PH_WDATA;
                            end else begin
                                phase_q  <= PH_RDATA;
                                rd_req_q <= 1'b1;
                            end
                        end else begin
                            acnt_q <= acnt_q + 1'b1;
                        end
                    end
                    PH_RDATA: begin
                        rd_req_q <= 1'b1;
                    end
                    PH_WDATA: begin
                        if (wr_ok_q) begin
                            we_q    <= 1'b1;
                            waddr_q <= addr_q;
                            wdata_q <= byte_val;
                            addr_q  <= addr_q + 1'b1;
                        end
                    end
                    PH_STATW: begin
                        if (wr_ok_q) begin
                            stat_q <= merge_status(stat_q, byte_val);
                        end
                        phase_q <= PH_SKIP;
                    end
                    default: ;
                endcase
            end
        end
    end

    // output bit picked by the receive bit index: ~idx == BYTE_W-1-idx
    assign out_byte = (phase_q == PH_STATR) ? stat_view : tx_q;
    assign miso_oe  = active && (phase_q == PH_RDATA || phase_q == PH_STATR);
    assign miso     = miso_oe & out_byte[~bit_idx];

endmodule

// File: rtl/spi_nvram_checker.sv
module spi_nvram_checker (
    input logic       clk,
    input logic       rst,
    input logic       wel,
    input logic       sleeping,
    input logic       mem_we,
    input logic       miso_oe,
    input logic       cs_act,
    input logic       cs_rise,
    input logic [7:0] stat
);

    // R4: an array write is only issued while the flag was set
    a_r4_write_needs_wel: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(wel));

    // R7: the flag only moves as select is released
    a_r7_wel_moves_at_cs_rise: assert property (@(posedge clk) disable iff (rst)
        ($rose(wel) || $fell(wel)) |-> $past(cs_rise));

    // R8: the status byte only changes while the flag is set
    a_r8_status_needs_wel: assert property (@(posedge clk) disable iff (rst)
        !$stable(stat) |-> $past(wel));

    // R10: sleep starts only on a select release
    a_r10_sleep_at_cs_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(sleeping) |-> $past(cs_rise));

    // R11: waking needs an asserted select
    a_r11_wake_on_select: assert property (@(posedge clk) disable iff (rst)
        $fell(sleeping) |-> $past(cs_act));

    // R13: data out is driven only after select was already asserted
    a_r13_drive_follows_select: assert property (@(posedge clk) disable iff (rst)
        miso_oe |-> $past(cs_act));

endmodule

bind spi_nvram_slave spi_nvram_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .wel      (wel_q),
    .sleeping (sleep_q),
    .mem_we   (we_q),
    .miso_oe  (miso_oe),
    .cs_act   (ev.cs_act),
    .cs_rise  (ev.cs_rise),
    .stat     (stat_q)
);

// File: tb/spi_nvram_slave_test.sv
module spi_nvram_slave_test;

    localparam int ADDR_W = 10;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int H      = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso;
    logic miso_oe;

    always #5 clk = ~clk;

    spi_nvram_slave #(.ADDR_W(ADDR_W)) uut (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .sck     (sck),
        .mosi    (mosi),
        .miso    (miso),
        .miso_oe (miso_oe)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int stray   = 0;
    bit drive_ok = 1'b0;
    bit mode3 = 1'b0;
    bit done = 1'b0;

    // behavioural reference model
    logic [7:0] m_mem [DEPTH];
    bit         m_wel = 1'b0;
    bit         m_sleep = 1'b0;
    logic [7:0] m_stat = 8'h00;

    logic [7:0] rx_q [$];
    bit         rx_oe [$];

    always @(negedge clk) begin
        if (!rst && miso_oe && !drive_ok) stray++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp_v);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp_v);
        end
    endtask

    task automatic bit_cycle(input logic din, output logic dout, inout bit oe_acc);
        if (mode3) sck = 1'b0;
        mosi = din;
        repeat (H) @(negedge clk);
        dout = miso;
        oe_acc = oe_acc & miso_oe;
        sck = 1'b1;
        repeat (H) @(negedge clk);
        if (!mode3) sck = 1'b0;
    endtask

    task automatic xact(input logic [7:0] tx[$], input int tail_bits, input bit may_drive);
        rx_q.delete();
        rx_oe.delete();
        sck = mode3;
        repeat (H) @(negedge clk);
        drive_ok = may_drive;
        cs_n = 1'b0;
        repeat (H) @(negedge clk);
        foreach (tx[i]) begin
            logic [7:0] r;
            bit oe_all;
            oe_all = 1'b1;
            for (int b = 7; b >= 0; b--) bit_cycle(tx[i][b], r[b], oe_all);
            rx_q.push_back(r);
            rx_oe.push_back(oe_all);
        end
        for (int b = 0; b < tail_bits; b++) begin
            logic d;
            bit o;
            o = 1'b1;
            bit_cycle(1'b1, d, o);
        end
        repeat (H) @(negedge clk);
        cs_n = 1'b1;
        repeat (2 * H) @(negedge clk);
        drive_ok = 1'b0;
        repeat (2 * H) @(negedge clk);
    endtask

    task automatic cmd(input logic [7:0] opc);
        logic [7:0] t [$];
        bit disc;
        disc = m_sleep;
        t.push_back(opc);
        xact(t, 0, 1'b0);
        if (disc) m_sleep = 1'b0;
        else if (opc == 8'h06) m_wel = 1'b1;
        else if (opc == 8'h04) m_wel = 1'b0;
        else if (opc == 8'hB9) m_sleep = 1'b1;
    endtask

    task automatic wr(input logic [23:0] addr, input logic [7:0] d[$], input int tail);
        logic [7:0] t [$];
        bit disc;
        disc = m_sleep;
        t.push_back(8'h02);
        t.push_back(addr[23:16]);
        t.push_back(addr[15:8]);
        t.push_back(addr[7:0]);
        foreach (d[i]) t.push_back(d[i]);
        xact(t, tail, 1'b0);
        if (disc) m_sleep = 1'b0;
        else begin
            if (m_wel) foreach (d[i]) m_mem[(int'(addr) + i) % DEPTH] = d[i];
            m_wel = 1'b0;
        end
    endtask

    task automatic rd(input logic [23:0] addr, input int n, input string req);
        logic [7:0] t [$];
        bit disc;
        disc = m_sleep;
        t.push_back(8'h03);
        t.push_back(addr[23:16]);
        t.push_back(addr[15:8]);
        t.push_back(addr[7:0]);
        for (int i = 0; i < n; i++) t.push_back(8'h00);
        xact(t, 0, !disc);
        if (disc) m_sleep = 1'b0;
        for (int i = 0; i < n; i++) begin
            logic [7:0] e;
            e = m_mem[(int'(addr) + i) % DEPTH];
            if (disc) check(!rx_oe[4+i], req, "read while waking must stay undriven", int'(rx_oe[4+i]), 0);
            else check(rx_oe[4+i] && rx_q[4+i] == e, req, "read data", int'(rx_q[4+i]), int'(e));
        end
    endtask

    task automatic rdsr(input int n, input string req);
        logic [7:0] t [$];
        logic [7:0] e;
        bit disc;
        disc = m_sleep;
        t.push_back(8'h05);
        for (int i = 0; i < n; i++) t.push_back(8'h00);
        xact(t, 0, !disc);
        if (disc) m_sleep = 1'b0;
        e = m_stat | (m_wel ? 8'h02 : 8'h00);
        for (int i = 1; i <= n; i++) begin
            if (disc) check(!rx_oe[i], req, "status while waking must stay undriven", int'(rx_oe[i]), 0);
            else check(rx_oe[i] && rx_q[i] == e, req, "status byte", int'(rx_q[i]), int'(e));
        end
    endtask

    task automatic wrsr(input logic [7:0] v);
        logic [7:0] t [$];
        t.push_back(8'h01);
        t.push_back(v);
        xact(t, 0, 1'b0);
        if (m_wel) m_stat = v & 8'h8C;
        m_wel = 1'b0;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] d [$];
        repeat (6) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);

        // R1: reset state
        check(miso_oe == 1'b0, "R1", "miso_oe after reset", int'(miso_oe), 0);
        rdsr(1, "R1");

        // R5, R7: enabled write, flag dropped afterwards
        cmd(8'h06);
        rdsr(2, "R3");
        d = '{8'hAA, 8'h55, 8'h0F, 8'hF0};
        wr(24'h000010, d, 0);
        rdsr(1, "R7");
        // R4: write without enable is ignored
        d = '{8'h11, 8'h22};
        wr(24'h000010, d, 0);
        rd(24'h000010, 4, "R4");
        rd(24'h000011, 3, "R6");

        // R7: disable command clears flag
        cmd(8'h06);
        cmd(8'h04);
        rdsr(1, "R7");

        // R5, R6: wrap at top, upper address bits dropped
        cmd(8'h06);
        d = '{8'h3C, 8'hC3, 8'h5A, 8'hA5, 8'h69};
        wr(24'hFC03FE, d, 0);
        rd(24'h0003FE, 5, "R5");
        rd(24'h7F83FF, 3, "R6");

        // R2: mode 3
        mode3 = 1'b1;
        cmd(8'h06);
        d = '{8'h81, 8'h7E, 8'hE7};
        wr(24'h000200, d, 0);
        rd(24'h000200, 3, "R2");
        rdsr(1, "R2");
        mode3 = 1'b0;
        rd(24'h000201, 2, "R2");

        // R8: status write with and without enable
        cmd(8'h06);
        wrsr(8'hFF);
        rdsr(1, "R8");
        wrsr(8'h00);
        rdsr(1, "R8");
        cmd(8'h06);
        wrsr(8'h04);
        rdsr(2, "R8");

        // R9: unknown command drives nothing and keeps the flag
        cmd(8'h06);
        d = '{8'hAB, 8'h03, 8'h00, 8'h00, 8'h10, 8'h00};
        xact(d, 0, 1'b0);
        check(rx_oe[5] == 1'b0, "R9", "unknown command drive", int'(rx_oe[5]), 0);
        rdsr(1, "R9");
        cmd(8'h04);

        // R12: trailing partial byte not written
        cmd(8'h06);
        d = '{8'h11, 8'h99};
        wr(24'h000100, d, 0);
        cmd(8'h06);
        d = '{8'h77};
        wr(24'h000100, d, 4);
        rd(24'h000100, 2, "R12");

        // R10, R11: sleep, noise, wake discard
        cmd(8'hB9);
        for (int i = 0; i < 16; i++) begin
            sck = ~sck;
            mosi = i[1];
            repeat (H) @(negedge clk);
        end
        sck = 1'b0;
        check(miso_oe == 1'b0, "R10", "asleep output enable", int'(miso_oe), 0);
        rdsr(1, "R10");
        rdsr(1, "R11");
        cmd(8'hB9);
        cmd(8'h06);
        rdsr(1, "R11");
        rd(24'h000010, 2, "R11");

        // R13: no stray drive seen at any clock
        check(stray == 0, "R13", "cycles driven outside data phase", stray, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule